// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is a clocked behavioural model of the command state machine in an 8-bit parallel NOR flash. It watches single-cycle bus writes (address, data, write enable). It recognises the unlock prefix, the standard byte program, chip erase, and a fast-program mode that is entered once and then needs only two writes per byte. A recognised command starts an embedded operation. While the operation runs, reads return a status byte. When the operation ends, the block goes back to returning array data. The array is a small internal register file of `MEM_WORDS` bytes, indexed by the low address bits.

Command cycles are matched on `addr[10:0]`:

| Cycle | Address | Data |
|-------|---------|------|
| Unlock 1 | 555h | AAh |
| Unlock 2 | 2AAh | 55h |
| Program command | 555h | A0h |
| Fast-mode entry | 555h | 20h |
| Erase set-up | 555h | 80h |
| Chip-erase command | 555h | 10h |

The embedded operations last a fixed number of clock cycles, set by `PROG_CYCLES` and `ERASE_CYCLES`. Reads are registered: `rd_data` takes its new value at the clock edge that samples `rd_en` high.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After `rst_n` is asserted, `rd_data` is 00h, the decoder is in array-read mode, and the status toggle bit is cleared. The array contents are not touched by reset.
- R2: A standard program is four writes: AAh@555h, 55h@2AAh, A0h@555h, then the target address and data byte. At completion the target cell holds the old value AND the data byte.
- R3: While an operation runs, a read returns a status byte with the following fields. Bit 7 is the inverse of bit 7 of the byte being programmed, and is 0 during erase. Bit 6 changes value on every such read. Bit 5 is the fail flag. Bits 4:0 are zero.
- R4: An operation lasts exactly `PROG_CYCLES` (program) or `ERASE_CYCLES` (erase) clock edges after the write that starts it. Every write during that time is ignored. After it ends, reads return array data.
- R5: A program that tries to turn a 0 bit into a 1 leaves that bit at 0. That program sets status bit 5 to 1 while it runs.
- R6: AAh@555h, 55h@2AAh, 20h@555h enters fast mode. In fast mode, A0h (any address) followed by the address and data byte programs one byte. The pair may be repeated.
- R7: In fast mode every write other than A0h and 90h is ignored, including full unlock prefixes. A 90h followed by anything other than 00h leaves the decoder in fast mode.
- R8: In fast mode, 90h followed by 00h (any addresses) returns the decoder to normal mode. After that, a lone A0h plus a data write programs nothing.
- R9: Chip erase is six writes: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. It zeroes the whole array at once. At completion every cell reads FFh.
- R10: A write that does not fit the expected next cycle of a sequence returns the decoder to idle. That write does not itself start a new sequence.
- R11: Asserting `rst_n` during an operation aborts it. An aborted program leaves its target unchanged. An aborted erase leaves the array zeroed. Reset also leaves fast mode.
- R12: `rd_data` changes only at an edge that samples `rd_en` high. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| rd_en | input | 1 | One-cycle bus read strobe |
| addr | input | ADDR_W | Bus address for reads and writes |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data: array byte or status byte |

## Verification
A wrong decoder state shows at the ports in one of three ways:
- a program that lands where it should not, or is missing, shown by the next array read;
- a status byte read at a time when array data is expected;
- array data read at a time when a status byte is expected.

Because the bench predicts `rd_data` on every clock, a busy window that is too long or too short is caught on the first read past its end. A missed or spurious mode change shows within one read after the data write that follows it.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int ADDR_W       = 17,
  parameter int MEM_WORDS    = 64,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_data
);

  localparam int IDX_W   = $clog2(MEM_WORDS);
  localparam int LONGEST = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  typedef enum logic [3:0] {
    S_READ, S_UL1, S_UL2, S_PGM, S_ES1, S_ES2, S_ES3,
    S_BYP, S_BPGM, S_BRST, S_BUSY
  } st_t;

  st_t              state, nxt;
  logic [CNT_W-1:0] cnt;
  logic             op_erase, ret_byp, dq5, tgl;
  logic [IDX_W-1:0] tgt_addr;
  logic [7:0]       tgt_data;
  logic [7:0]       mem [MEM_WORDS];
  logic             unused_hi;

  wire [IDX_W-1:0] idx    = addr[IDX_W-1:0];
  wire             at_555 = addr[10:0] == 11'h555;
  wire             at_2aa = addr[10:0] == 11'h2AA;
  wire             is_busy = state == S_BUSY;
  wire             done    = is_busy && cnt == '0;
  wire             start_pgm = wr_en && (state == S_PGM || state == S_BPGM);
  wire             start_ers = wr_en && state == S_ES3 && at_555 && wdata == 8'h10;
  wire [7:0]       status  = {~tgt_data[7], tgl, dq5, 5'b0};

  assign unused_hi = ^addr[ADDR_W-1:11];

  always_comb begin
    nxt = state;
    if (wr_en) begin
      case (state)
        S_READ: nxt = (at_555 && wdata == 8'hAA) ? S_UL1 : S_READ;
        S_UL1:  nxt = (at_2aa && wdata == 8'h55) ? S_UL2 : S_READ;
        S_UL2: begin
          if (at_555 && wdata == 8'hA0)      nxt = S_PGM;
          else if (at_555 && wdata == 8'h20) nxt = S_BYP;
          else if (at_555 && wdata == 8'h80) nxt = S_ES1;
          else                               nxt = S_READ;
        end
        S_PGM:  nxt = S_BUSY;
        S_ES1:  nxt = (at_555 && wdata == 8'hAA) ? S_ES2 : S_READ;
        S_ES2:  nxt = (at_2aa && wdata == 8'h55) ? S_ES3 : S_READ;
        S_ES3:  nxt = (at_555 && wdata == 8'h10) ? S_BUSY : S_READ;
        S_BYP: begin
          if (wdata == 8'hA0)      nxt = S_BPGM;
          else if (wdata == 8'h90) nxt = S_BRST;
          else                     nxt = S_BYP;
        end
        S_BPGM: nxt = S_BUSY;
        S_BRST: nxt = (wdata == 8'h00) ? S_READ : S_BYP;
        default: nxt = state;
      endcase
    end
    if (done) nxt = ret_byp ? S_BYP : S_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_READ;
      cnt      <= '0;
      op_erase <= 1'b0;
      ret_byp  <= 1'b0;
      tgt_addr <= '0;
      tgt_data <= '0;
      dq5      <= 1'b0;
      tgl      <= 1'b0;
      rd_data  <= '0;
    end else begin
      state <= nxt;
      if (rd_en) begin
        if (is_busy) begin
          rd_data <= status;
          tgl     <= ~tgl;
        end else begin
          rd_data <= mem[idx];
        end
      end
      if (is_busy && cnt != '0) cnt <= cnt - 1'b1;
      if (start_pgm) begin
        cnt      <= CNT_W'(PROG_CYCLES - 1);
        op_erase <= 1'b0;
        ret_byp  <= state == S_BPGM;
        tgt_addr <= idx;
        tgt_data <= wdata;
        dq5      <= |(wdata & ~mem[idx]);
      end
      if (start_ers) begin
        cnt      <= CNT_W'(ERASE_CYCLES - 1);
        op_erase <= 1'b1;
        ret_byp  <= 1'b0;
        tgt_data <= 8'hFF;
        dq5      <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (start_ers) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= 8'h00;
    end else if (done) begin
      if (op_erase) begin
        for (int i = 0; i < MEM_WORDS; i++) mem[i] <= 8'hFF;
      end else begin
        mem[tgt_addr] <= mem[tgt_addr] & tgt_data;
      end
    end
  end

  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    is_busy && cnt != '0 |=> is_busy);

  a_r3_dq6_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && is_busy && $past(rd_en && is_busy) |=> rd_data[6] != $past(rd_data[6]));

  a_r7_bypass_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_BYP && wr_en && wdata != 8'hA0 && wdata != 8'h90 |=> state == S_BYP);

  a_r8_bypass_exit: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_BRST && wr_en && wdata == 8'h00 |=> state == S_READ);

  a_r9_erase_fills: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_erase |=> mem[0] == 8'hFF && mem[MEM_WORDS-1] == 8'hFF);

  a_r10_bad_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_UL1 && wr_en && !(at_2aa && wdata == 8'h55) |=> state == S_READ);

endmodule

// File: tb/flash_cmd_fsm_tb_top.sv
module flash_cmd_fsm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 17;
  localparam int W = 64;
  localparam int PC = 6;
  localparam int EC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .MEM_WORDS(W), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data));

  int m_mem [W];
  int seq_a [$];
  int seq_d [$];
  int m_mode, busy_left, m_kind, m_tgt_a, m_tgt_d, m_dq5, m_tgl, exp_rd;
  int errors = 0, checks = 0;
  bit finished = 0;
  string req = "R1";
  logic [7:0] v1;

  task automatic check(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", r, act, exp, $time);
    end
  endtask

  function automatic bit is555(int a); return (a & 'h7FF) == 'h555; endfunction
  function automatic bit is2aa(int a); return (a & 'h7FF) == 'h2AA; endfunction

  task automatic model_reset();
    m_mode = 0; busy_left = 0; m_tgl = 0; exp_rd = 0;
    seq_a.delete(); seq_d.delete();
  endtask

  task automatic start_prog(int a, int d);
    int i = a % W;
    m_dq5 = ((d & ~m_mem[i] & 255) != 0);
    m_tgt_a = i; m_tgt_d = d; m_kind = 0; busy_left = PC;
  endtask

  task automatic start_erase();
    foreach (m_mem[i]) m_mem[i] = 0;
    m_tgt_d = 255; m_dq5 = 0; m_kind = 1; busy_left = EC;
  endtask

  task automatic decode(int a, int d);
    bit keep;
    int n;
    seq_a.push_back(a); seq_d.push_back(d);
    n = seq_d.size();
    keep = 0;
    if (m_mode == 1) begin
      if (n == 1) keep = (d == 'hA0 || d == 'h90);
      else if (seq_d[0] == 'hA0) start_prog(a, d);
      else if (d == 0) m_mode = 0;
    end else begin
      case (n)
        1: keep = is555(a) && d == 'hAA;
        2: keep = is2aa(a) && d == 'h55;
        3: begin
          keep = is555(a) && (d == 'hA0 || d == 'h80);
          if (is555(a) && d == 'h20) m_mode = 1;
        end
        4: if (seq_d[2] == 'hA0) start_prog(a, d);
           else keep = is555(a) && d == 'hAA;
        5: keep = is2aa(a) && d == 'h55;
        6: if (is555(a) && d == 'h10) start_erase();
        default: keep = 0;
      endcase
    end
    if (!keep) begin seq_a.delete(); seq_d.delete(); end
  endtask

  task automatic model_step(bit w, bit r, int a, int d);
    if (r) begin
      if (busy_left > 0) begin
        exp_rd = (((m_tgt_d >> 7) & 1) ? 0 : 128) | (m_tgl ? 64 : 0) | (m_dq5 ? 32 : 0);
        m_tgl = !m_tgl;
      end else exp_rd = m_mem[a % W];
    end
    if (busy_left > 0) begin
      busy_left--;
      if (busy_left == 0) begin
        if (m_kind == 1) foreach (m_mem[i]) m_mem[i] = 255;
        else m_mem[m_tgt_a] = m_mem[m_tgt_a] & m_tgt_d;
      end
    end else if (w) decode(a, d);
  endtask

  task automatic cyc(bit w, bit r, int a, int d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = ADDR_W'(a); wdata = 8'(d);
    model_step(w, r, a, d);
    @(posedge clk); #1;
    check(req, rd_data, 8'(exp_rd));
  endtask

  task automatic wr(int a, int d); cyc(1, 0, a, d); endtask
  task automatic rd(int a); cyc(0, 1, a, 0); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0); endtask
  task automatic rd_expect(int a, logic [7:0] e, string r); rd(a); check(r, rd_data, e); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; rd_en = 0;
    model_reset();
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic unlock(); wr('h555, 'hAA); wr('h2AA, 'h55); endtask
  task automatic erase_cmd(); unlock(); wr('h555, 'h80); unlock(); wr('h555, 'h10); endtask

  initial begin
    foreach (m_mem[i]) m_mem[i] = 255;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1 check("R1", rd_data, 8'h00);

    req = "R9";
    erase_cmd();
    rd(0); v1 = rd_data; check("R3", rd_data & 8'hA0, 8'h00);
    rd(0); check("R3", (rd_data ^ v1) & 8'h40, 8'h40);
    idle(EC);
    rd_expect(0, 8'hFF, "R9"); rd_expect(W-1, 8'hFF, "R9");

    req = "R2";
    unlock(); wr('h555, 'hA0); wr(5, 'hA5);
    rd(5); check("R3", rd_data & 8'hBF, 8'h00);
    wr(5, 'h00);
    idle(PC);
    rd_expect(5, 8'hA5, "R2"); rd_expect(5 + W, 8'hA5, "R4");

    req = "R5";
    unlock(); wr('h555, 'hA0); wr(5, 'h5A);
    rd(5); check("R5", rd_data & 8'hA0, 8'hA0);
    idle(PC);
    rd_expect(5, 8'h00, "R5");

    req = "R10";
    unlock(); wr('h555, 'h33); wr('h555, 'hA0); wr(7, 'h12);
    idle(PC); rd_expect(7, 8'hFF, "R10");
    wr('h555, 'hAA); wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA0); wr(8, 'h00);
    idle(PC); rd_expect(8, 8'hFF, "R10");

    req = "R6";
    unlock(); wr('h555, 'h20);
    wr('h123, 'hA0); wr(9, 'h3C); idle(PC);
    wr('h000, 'hA0); wr(10, 'hC3); idle(PC);
    rd_expect(9, 8'h3C, "R6"); rd_expect(10, 8'hC3, "R6");

    req = "R7";
    unlock(); wr('h555, 'h80); wr('h555, 'h10); idle(2);
    wr(0, 'h90); wr(11, 'h12); idle(2);
    rd_expect(11, 8'hFF, "R7");
    wr(0, 'hA0); wr(11, 'h0F); idle(PC);
    rd_expect(11, 8'h0F, "R7"); rd_expect(9, 8'h3C, "R7");

    req = "R12";
    rd(9); idle(1); check("R12", rd_data, 8'h3C);
    wr(0, 'h77); check("R12", rd_data, 8'h3C);

    req = "R8";
    wr('h1234, 'h90); wr('h777, 'h00);
    wr('h555, 'hA0); wr(12, 'h00); idle(PC);
    rd_expect(12, 8'hFF, "R8");

    req = "R11";
    unlock(); wr('h555, 'hA0); wr(13, 'h00); idle(2);
    do_reset(); check("R11", rd_data, 8'h00);
    rd_expect(13, 8'hFF, "R11");
    unlock(); wr('h555, 'h20); do_reset();
    wr(0, 'hA0); wr(14, 'h00); idle(PC);
    rd_expect(14, 8'hFF, "R11");
    erase_cmd(); idle(3); do_reset();
    rd_expect(0, 8'h00, "R11"); rd_expect(20, 8'h00, "R11");
    req = "R9";
    erase_cmd(); idle(EC);
    rd_expect(20, 8'hFF, "R9");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R4: watchdog expired, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule